// File: doc/BRIEF.md
# Pixel Row Readout with Double-Buffered Column Memory and Output Stream

After each analog-to-digital conversion phase, every pixel of the array holds one converted word in its local memory. This block moves those words off the array. A single conversion-done strobe starts a frame transfer. The transfer walks the rows in ascending order and senses one pixel word per clock through the column bus lines. Each word goes into a column memory that holds two row-sized banks. As each bank fills, a streaming stage empties it through the output multiplexer. Words leave as a serial sequence with a valid strobe and two markers: one for the start of a row and one for the start of a frame.

The two banks alternate row by row, so a row being streamed is never overwritten by the next row's transfer. The transfer stalls when both banks are full and resumes when one is drained. The column sense enable stays low whenever the counter bus drivers are active, because those drivers own the bus lines during conversion. A read that is due while the drivers are on simply waits.

Frames do not queue. If a conversion-done strobe arrives while an earlier frame still has words that have not been presented, the block raises a one-cycle overrun flag. It ignores that strobe and finishes the earlier frame untouched.

Top module: `frame_readout`

## Requirements
- R1: No pixel read (`pix_rd` high) occurs before a `conv_done` strobe has been accepted. After an accepted strobe, the transfer of that frame begins without any further input.
- R2: `sense_en` is high only while a frame transfer is in progress and `cnt_bus_en` is low. `pix_rd` is high only in cycles where `sense_en` is high.
- R3: Reads within a frame go row 0 up to row ROWS-1. Within each row they go column 0 up to column COLS-1, and two successive reads of the same row address adjacent columns.
- R4: A stored word takes bit i = 1 exactly when bus line i of `pix_bits` is asserted (the pixel memory sinks current), and bit i = 0 otherwise. The lines are sampled at the clock edge that ends a cycle in which `pix_rd` is high.
- R5: Each accepted frame produces exactly ROWS×COLS output words, one per cycle with `out_valid` high. They come in row-major order: row 0 first, columns ascending. Each `out_word` equals the value sensed for that pixel.
- R6: `out_row_start` is high together with the first word of every row. `out_frame_start` is high only together with the first word of row 0. Neither marker is ever high without `out_valid`.
- R7: The COLS words of one row leave on consecutive cycles. Idle cycles appear only between rows.
- R8: A frame counts as busy from the cycle its `conv_done` is accepted until its last word has been presented. A `conv_done` sampled while a frame is busy makes `overrun` high for exactly the next cycle. That strobe starts nothing, and the busy frame's words continue unchanged.
- R9: A `conv_done` sampled while no frame is busy is accepted and leaves `overrun` low.
- R10: While `rst` is high, and on the cycle after it, all outputs are low.
- R11: Raising `cnt_bus_en` during a transfer halts reads for as long as it stays high. When it falls, the transfer continues with no word lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done | input | 1 | One-cycle strobe marking the end of the conversion phase |
| cnt_bus_en | input | 1 | High while the counter bus drivers own the column bus lines |
| sense_en | output | 1 | Column sense circuits enable |
| pix_rd | output | 1 | Read strobe to the selected pixel row |
| pix_row | output | $clog2(ROWS) | Row address being read |
| pix_col | output | $clog2(COLS) | Column address being read |
| pix_bits | input | WIDTH | Sensed bus lines, 1 where the pixel memory sinks current |
| out_valid | output | 1 | Output word valid |
| out_word | output | WIDTH | Output pixel word |
| out_row_start | output | 1 | First word of a row |
| out_frame_start | output | 1 | First word of a frame |
| overrun | output | 1 | One-cycle flag: a conversion strobe arrived while a frame was busy |

## Verification
The bench builds the block with COLS=6, ROWS=4 and WIDTH=7. With these values a whole frame drains in a few dozen cycles. Each bank is refilled twice per frame, so the stall of the transfer behind a full bank and the wrap of both the row counter and the bank select are hit in every frame. The small word width lets one frame carry alternating all-ones and all-zero words, so every bus line is seen in both states. The size also leaves room to raise `cnt_bus_en` in the middle of a transfer and to send repeated, back-to-back strobes while a frame is still streaming.

// File: rtl/frame_readout_pkg.sv
package frame_readout_pkg;
  // Number of column memory banks used for ping-pong buffering
  localparam int unsigned FR_BANKS = 2;

  // Markers that travel alongside a word through the read pipeline
  typedef struct packed {
    logic row_first;
    logic frame_first;
  } fr_tag_t;
endpackage

// File: rtl/fr_colmem.sv
// Two row-sized banks in one simple dual-port memory; registered read port.
module fr_colmem #(
  parameter int unsigned WIDTH = 15,
  parameter int unsigned DEPTH = 1280,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/fr_xfer.sv
// Row sequencer: walks the array one pixel word per clock into the free bank.
module fr_xfer
  import frame_readout_pkg::*;
#(
  parameter int unsigned COLS  = 640,
  parameter int unsigned ROWS  = 512,
  parameter int unsigned WIDTH = 15,
  localparam int unsigned COL_W = $clog2(COLS),
  localparam int unsigned ROW_W = $clog2(ROWS),
  localparam int unsigned AW    = $clog2(2 * COLS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                cnt_bus_en,
  input  logic [FR_BANKS-1:0] bank_full,
  input  logic [WIDTH-1:0]    pix_bits,
  output logic                active,
  output logic                sense_en,
  output logic                pix_rd,
  output logic [ROW_W-1:0]    pix_row,
  output logic [COL_W-1:0]    pix_col,
  output logic                we,
  output logic [AW-1:0]       waddr,
  output logic [WIDTH-1:0]    wdata,
  output logic                fill_done,
  output logic                fill_bank
);
  logic             act_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             wb_q;
  logic             go;
  logic             last_col;
  logic             last_row;

  assign last_col = (col_q == COL_W'(COLS - 1));
  assign last_row = (row_q == ROW_W'(ROWS - 1));
  // A read happens only when the bus is ours and the target bank is empty
  assign go = act_q & ~cnt_bus_en & ~bank_full[wb_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      row_q <= '0;
      col_q <= '0;
      wb_q  <= 1'b0;
    end else if (start) begin
      act_q <= 1'b1;
      row_q <= '0;
      col_q <= '0;
    end else if (go) begin
      if (last_col) begin
        col_q <= '0;
        wb_q  <= ~wb_q;
        if (last_row) act_q <= 1'b0;
        else          row_q <= row_q + 1'b1;
      end else begin
        col_q <= col_q + 1'b1;
      end
    end
  end

  assign active    = act_q;
  assign sense_en  = act_q & ~cnt_bus_en;
  assign pix_rd    = go;
  assign pix_row   = row_q;
  assign pix_col   = col_q;
  assign we        = go;
  assign waddr     = (wb_q ? AW'(COLS) : AW'(0)) + AW'(col_q);
  assign wdata     = pix_bits;
  assign fill_done = go & last_col;
  assign fill_bank = wb_q;
endmodule

// File: rtl/fr_stream.sv
// Output multiplexer: empties one full bank per row through a two-stage pipe.
module fr_stream
  import frame_readout_pkg::*;
#(
  parameter int unsigned COLS  = 640,
  parameter int unsigned ROWS  = 512,
  parameter int unsigned WIDTH = 15,
  localparam int unsigned COL_W = $clog2(COLS),
  localparam int unsigned ROW_W = $clog2(ROWS),
  localparam int unsigned AW    = $clog2(2 * COLS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [FR_BANKS-1:0] bank_full,
  input  logic [WIDTH-1:0]    rdata,
  output logic                re,
  output logic [AW-1:0]       raddr,
  output logic                drain_done,
  output logic                drain_bank,
  output logic                pipe_busy,
  output logic                out_valid,
  output logic [WIDTH-1:0]    out_word,
  output logic                out_row_start,
  output logic                out_frame_start
);
  logic             on_q;
  logic             rb_q;
  logic [COL_W-1:0] k_q;
  logic [ROW_W-1:0] orow_q;
  logic             p_v;
  fr_tag_t          p_tag;
  logic             last_k;

  assign last_k = (k_q == COL_W'(COLS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q            <= 1'b0;
      rb_q            <= 1'b0;
      k_q             <= '0;
      orow_q          <= '0;
      p_v             <= 1'b0;
      p_tag           <= '0;
      out_valid       <= 1'b0;
      out_word        <= '0;
      out_row_start   <= 1'b0;
      out_frame_start <= 1'b0;
    end else begin
      if (!on_q) begin
        if (bank_full[rb_q]) begin
          on_q <= 1'b1;
          k_q  <= '0;
        end
      end else if (last_k) begin
        on_q   <= 1'b0;
        rb_q   <= ~rb_q;
        k_q    <= '0;
        orow_q <= (orow_q == ROW_W'(ROWS - 1)) ? '0 : orow_q + 1'b1;
      end else begin
        k_q <= k_q + 1'b1;
      end
      // stage 1: memory read in flight
      p_v               <= on_q;
      p_tag.row_first   <= on_q & (k_q == '0);
      p_tag.frame_first <= on_q & (k_q == '0) & (orow_q == '0);
      // stage 2: registered outputs
      out_valid       <= p_v;
      out_word        <= p_v ? rdata : '0;
      out_row_start   <= p_tag.row_first;
      out_frame_start <= p_tag.frame_first;
    end
  end

  assign re         = on_q;
  assign raddr      = (rb_q ? AW'(COLS) : AW'(0)) + AW'(k_q);
  assign drain_done = on_q & last_k;
  assign drain_bank = rb_q;
  assign pipe_busy  = on_q | p_v;
endmodule

// File: rtl/frame_readout.sv
module frame_readout
  import frame_readout_pkg::*;
#(
  parameter int unsigned COLS  = 640,
  parameter int unsigned ROWS  = 512,
  parameter int unsigned WIDTH = 15,
  localparam int unsigned COL_W = $clog2(COLS),
  localparam int unsigned ROW_W = $clog2(ROWS),
  localparam int unsigned AW    = $clog2(2 * COLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_done,
  input  logic             cnt_bus_en,
  output logic             sense_en,
  output logic             pix_rd,
  output logic [ROW_W-1:0] pix_row,
  output logic [COL_W-1:0] pix_col,
  input  logic [WIDTH-1:0] pix_bits,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_word,
  output logic             out_row_start,
  output logic             out_frame_start,
  output logic             overrun
);
  logic [FR_BANKS-1:0] full_q;
  logic                xfer_active;
  logic                we;
  logic [AW-1:0]       waddr;
  logic [WIDTH-1:0]    wdata;
  logic                fill_done;
  logic                fill_bank;
  logic                re;
  logic [AW-1:0]       raddr;
  logic [WIDTH-1:0]    rdata;
  logic                drain_done;
  logic                drain_bank;
  logic                pipe_busy;
  logic                busy;
  logic                accept;

  // A frame is busy until its last word has left the read pipeline
  assign busy   = xfer_active | (|full_q) | pipe_busy;
  assign accept = conv_done & ~busy;

  always_ff @(posedge clk) begin
    if (rst) overrun <= 1'b0;
    else     overrun <= conv_done & busy;
  end

  for (genvar b = 0; b < FR_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)                                       full_q[b] <= 1'b0;
      else if (fill_done && (fill_bank == 1'(b)))    full_q[b] <= 1'b1;
      else if (drain_done && (drain_bank == 1'(b)))  full_q[b] <= 1'b0;
    end
  end

  fr_xfer #(.COLS(COLS), .ROWS(ROWS), .WIDTH(WIDTH)) u_xfer (
    .clk        (clk),
    .rst        (rst),
    .start      (accept),
    .cnt_bus_en (cnt_bus_en),
    .bank_full  (full_q),
    .pix_bits   (pix_bits),
    .active     (xfer_active),
    .sense_en   (sense_en),
    .pix_rd     (pix_rd),
    .pix_row    (pix_row),
    .pix_col    (pix_col),
    .we         (we),
    .waddr      (waddr),
    .wdata      (wdata),
    .fill_done  (fill_done),
    .fill_bank  (fill_bank)
  );

  fr_colmem #(.WIDTH(WIDTH), .DEPTH(2 * COLS)) u_mem (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .re    (re),
    .raddr (raddr),
    .rdata (rdata)
  );

  fr_stream #(.COLS(COLS), .ROWS(ROWS), .WIDTH(WIDTH)) u_stream (
    .clk             (clk),
    .rst             (rst),
    .bank_full       (full_q),
    .rdata           (rdata),
    .re              (re),
    .raddr           (raddr),
    .drain_done      (drain_done),
    .drain_bank      (drain_bank),
    .pipe_busy       (pipe_busy),
    .out_valid       (out_valid),
    .out_word        (out_word),
    .out_row_start   (out_row_start),
    .out_frame_start (out_frame_start)
  );
endmodule

// File: rtl/frame_readout_chk.sv
module frame_readout_chk #(
  parameter int unsigned COLS = 640,
  parameter int unsigned ROWS = 512,
  localparam int unsigned COL_W = $clog2(COLS),
  localparam int unsigned ROW_W = $clog2(ROWS)
) (
  input logic             clk,
  input logic             rst,
  input logic             conv_done,
  input logic             cnt_bus_en,
  input logic             sense_en,
  input logic             pix_rd,
  input logic [ROW_W-1:0] pix_row,
  input logic [COL_W-1:0] pix_col,
  input logic             out_valid,
  input logic             out_row_start,
  input logic             out_frame_start,
  input logic             overrun
);
  logic        seen_start;
  int unsigned run_cnt;

  always_ff @(posedge clk) begin
    if (rst)            seen_start <= 1'b0;
    else if (conv_done) seen_start <= 1'b1;
  end

  // words of the current row already presented (0 = between rows)
  always_ff @(posedge clk) begin
    if (rst) run_cnt <= 0;
    else if (out_valid && out_row_start) run_cnt <= (COLS == 1) ? 0 : 1;
    else if (out_valid && run_cnt != 0)  run_cnt <= (run_cnt == COLS - 1) ? 0 : run_cnt + 1;
  end

  assert_read_after_conv_R1: assert property (@(posedge clk) disable iff (rst)
    pix_rd |-> seen_start);

  assert_sense_bus_off_R2: assert property (@(posedge clk) disable iff (rst)
    sense_en |-> !cnt_bus_en);

  assert_read_needs_sense_R2: assert property (@(posedge clk) disable iff (rst)
    pix_rd |-> sense_en);

  assert_col_step_R3: assert property (@(posedge clk) disable iff (rst)
    (pix_rd && $past(pix_rd) && ($past(pix_col) != COL_W'(COLS - 1)))
      |-> ((pix_col == $past(pix_col) + 1'b1) && (pix_row == $past(pix_row))));

  assert_row_marker_R6: assert property (@(posedge clk) disable iff (rst)
    out_row_start |-> out_valid);

  assert_frame_marker_R6: assert property (@(posedge clk) disable iff (rst)
    out_frame_start |-> out_row_start);

  assert_row_contiguous_R7: assert property (@(posedge clk) disable iff (rst)
    (run_cnt != 0) |-> out_valid);

  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (rst)
    overrun |-> $past(conv_done));
endmodule

bind frame_readout frame_readout_chk #(.COLS(COLS), .ROWS(ROWS)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .conv_done       (conv_done),
  .cnt_bus_en      (cnt_bus_en),
  .sense_en        (sense_en),
  .pix_rd          (pix_rd),
  .pix_row         (pix_row),
  .pix_col         (pix_col),
  .out_valid       (out_valid),
  .out_row_start   (out_row_start),
  .out_frame_start (out_frame_start),
  .overrun         (overrun)
);

// File: tb/frame_readout_test.sv
module frame_readout_test;
  localparam int COLS  = 6;
  localparam int ROWS  = 4;
  localparam int WIDTH = 7;
  localparam int COL_W = $clog2(COLS);
  localparam int ROW_W = $clog2(ROWS);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst;
  logic             conv_done;
  logic             cnt_bus_en;
  logic             sense_en;
  logic             pix_rd;
  logic [ROW_W-1:0] pix_row;
  logic [COL_W-1:0] pix_col;
  logic [WIDTH-1:0] pix_bits;
  logic             out_valid;
  logic [WIDTH-1:0] out_word;
  logic             out_row_start;
  logic             out_frame_start;
  logic             overrun;

  int pic;
  int errors = 0;
  int checks = 0;
  int words_seen = 0;
  int ovr_seen = 0;
  int accepted = 0;
  int cyc = 0;
  bit started = 1'b0;
  bit busy_m;
  logic [WIDTH+1:0] expq[$];   // {frame_start, row_start, word}
  logic [WIDTH+1:0] e;

  // Pixel contents the array presents for picture p
  function automatic logic [WIDTH-1:0] pixel_val(int p, int r, int c);
    if (p == 3) return (((r + c) % 2) == 1) ? {WIDTH{1'b1}} : {WIDTH{1'b0}};
    return WIDTH'(p * 37 + r * 11 + c * 3 + 5);
  endfunction

  always_comb pix_bits = pixel_val(pic, int'(pix_row), int'(pix_col));

  frame_readout #(.COLS(COLS), .ROWS(ROWS), .WIDTH(WIDTH)) uut (
    .clk             (clk),
    .rst             (rst),
    .conv_done       (conv_done),
    .cnt_bus_en      (cnt_bus_en),
    .sense_en        (sense_en),
    .pix_rd          (pix_rd),
    .pix_row         (pix_row),
    .pix_col         (pix_col),
    .pix_bits        (pix_bits),
    .out_valid       (out_valid),
    .out_word        (out_word),
    .out_row_start   (out_row_start),
    .out_frame_start (out_frame_start),
    .overrun         (overrun)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Reference model, evaluated after every rising edge
  always @(posedge clk) begin
    #2;
    if (!rst) begin
      busy_m = (expq.size() != 0);
      // R8 / R9: overrun follows a strobe sampled while busy, for one cycle
      check(overrun == (conv_done && busy_m), (conv_done && busy_m) ? "R8" : "R9",
            "overrun", int'(overrun), int'(conv_done && busy_m));
      if (overrun) ovr_seen++;
      if (out_valid) begin
        if (expq.size() == 0) begin
          check(1'b0, "R5", "unexpected word", int'(out_word), -1);
        end else begin
          e = expq.pop_front();
          words_seen++;
          check(out_word == e[WIDTH-1:0], "R5", "word", int'(out_word), int'(e[WIDTH-1:0]));
          check(out_row_start == e[WIDTH], "R6", "row start", int'(out_row_start), int'(e[WIDTH]));
          check(out_frame_start == e[WIDTH+1], "R6", "frame start", int'(out_frame_start), int'(e[WIDTH+1]));
        end
      end else if (out_row_start || out_frame_start) begin
        check(1'b0, "R6", "marker without valid", 1, 0);
      end
      if (conv_done && !busy_m) begin
        for (int r = 0; r < ROWS; r++)
          for (int c = 0; c < COLS; c++)
            expq.push_back({(r == 0 && c == 0), (c == 0), pixel_val(pic, r, c)});
        accepted++;
        started = 1'b1;
      end
      if (pix_rd) check(started, "R1", "read before conversion done", 1, 0);
      if (cnt_bus_en) check(!sense_en && !pix_rd, "R2", "sense while bus driven",
                            int'(sense_en) + 2 * int'(pix_rd), 0);
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL all: watchdog expired, actual %0d expected 0 pending", expq.size());
      summary();
      $finish;
    end
  end

  task automatic convert(input int p, input int hold);
    pic = p;
    cnt_bus_en = 1'b1;
    repeat (hold) @(negedge clk);
    cnt_bus_en = 1'b0;
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic pulse_conv();
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (expq.size() != 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1;
    conv_done = 1'b0;
    cnt_bus_en = 1'b0;
    pic = 0;
    repeat (4) @(negedge clk);
    // R10: reset state
    check(!out_valid && !out_row_start && !out_frame_start, "R10", "stream outputs in reset",
          int'(out_valid) + int'(out_row_start) + int'(out_frame_start), 0);
    check(!overrun && !pix_rd && !sense_en, "R10", "control outputs in reset",
          int'(overrun) + int'(pix_rd) + int'(sense_en), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!out_valid && !overrun && !pix_rd && !sense_en, "R10", "outputs after reset", 0, 0);
    // R1: idle, no reads happen
    repeat (6) @(negedge clk);

    // R5 R9: plain frame
    convert(0, 5);
    drain();

    // R11: bus taken back mid-transfer; R8: strobe while streaming
    convert(1, 5);
    repeat (9) @(negedge clk);
    cnt_bus_en = 1'b1;
    repeat (7) @(negedge clk);
    cnt_bus_en = 1'b0;
    repeat (4) @(negedge clk);
    pulse_conv();
    drain();

    // R4: alternating all-ones / all-zero words; back-to-back rejected strobes (R8)
    convert(3, 3);
    repeat (3) @(negedge clk);
    pulse_conv();
    pulse_conv();
    drain();

    // R9: normal frame after overruns
    convert(2, 4);
    drain();

    check(expq.size() == 0, "R5", "words left undelivered", expq.size(), 0);
    check(words_seen == 4 * ROWS * COLS, "R5", "total words", words_seen, 4 * ROWS * COLS);
    check(accepted == 4, "R9", "accepted frames", accepted, 4);
    check(ovr_seen == 3, "R8", "overrun pulses", ovr_seen, 3);
    summary();
    $finish;
  end
endmodule